// File: doc/BRIEF.md
# GPIO Event Detector with Grouped Interrupts

This block watches a set of already-synchronized input pins and records, per pin, when a selected condition occurs. For every pin, software may arm any mix of four conditions: a low-to-high transition, a high-to-low transition, the pin being high, and the pin being low. When an armed condition is seen, the pin's bit in an event status word is set and stays set until software writes a 1 to that bit. Transitions are found by comparing each pin's level with its level one clock earlier. Level conditions set the bit again on every clock for as long as the condition holds and its arm bit is set.

Pins are organised in 32-bit banks: pin p lives in bank p/32 at bit p%32. Three interrupt lines each report the OR of the pending status bits of a fixed run of pins. The runs cross the bank boundary. Two further per-pin words exist as plain read/write storage with no detection role. All registers are reached through a simple single-cycle write strobe and a combinational read port.

Top module: `gpio_evt_unit`

## Requirements
- R1: After synchronous reset, every arm word and both status words read 0 and all three interrupt lines are low.
- R2: With the rise arm bit set (word offsets 0x4C bank 0, 0x50 bank 1), a 0-to-1 change of that pin sets its status bit (offsets 0x40 bank 0, 0x44 bank 1) at the next clock edge; pins whose rise bit is clear record nothing.
- R3: With the fall arm bit set (offsets 0x58 / 0x5C), a 1-to-0 change of that pin sets its status bit.
- R4: With both the rise and fall bits set for a pin, transitions in either direction are recorded.
- R5: With the high-level arm bit set (offsets 0x64 / 0x68), the status bit is set on every clock on which the pin is high; once the arm bit is cleared and the status is cleared, it stays clear.
- R6: With the low-level arm bit set (offsets 0x70 / 0x74), the status bit is set on every clock on which the pin is low, and stops being set once the pin goes high.
- R7: Writing a status word clears exactly the bits written as 1; bits written as 0 keep their value.
- R8: When a condition is detected on the same clock as a clear of that status bit, the bit stays set.
- R9: A status bit that is pending when its arm bit is cleared remains set until software clears it.
- R10: Interrupt line 0 is high when any status bit of pins 0 to 27 is set, line 1 for pins 28 to 45 (bank 0 bits 28 to 31 and bank 1 bits 0 to 13), and line 2 for pins 46 to 53 (bank 1 bits 14 to 21).
- R11: The two extra words (offsets 0x7C / 0x80 and 0x88 / 0x8C) read back what was written and never cause a status bit to be set.
- R12: Per-pin words read back their written value; bits of bank 1 above pin 53 (bits 22 to 31) read as 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 8 | Byte offset of the word read or written |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_lvl | input | 54 | Synchronized pin levels |
| irq | output | 3 | Grouped interrupt lines |

## Verification
Each condition kind is driven alone on pins in both banks: single rising and falling steps separate the two edge detectors, a pin held high or low while its level arm is set separates level from edge behaviour, and a clear issued while the level still holds shows that a new event beats the clear. Pins 27, 28, 45 and 46 are raised one at a time so that the interrupt line that reacts shows where each group boundary lies, including the crossing from bank 0 into bank 1. Toggling a pin that is armed only through the storage-only words, and writing all ones to a bank 1 word, show that those paths touch no status and that absent pins read zero.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    // Byte offsets of bank 0 of each per-pin word; bank n sits 4*n above.
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RISE   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_FALL   = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_HIGH   = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_LOW    = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_ARISE  = 8'h7C;
    localparam logic [ADDR_W-1:0] OFS_AFALL  = 8'h88;

    typedef enum logic [2:0] {
        RK_NONE, RK_STATUS, RK_RISE, RK_FALL,
        RK_HIGH, RK_LOW, RK_ARISE, RK_AFALL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] bank;
    } reg_sel_t;

    function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input int banks);
        return (a >= base) && (int'(a - base) < 4 * banks);
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int banks);
        reg_sel_t s;
        logic [ADDR_W-1:0] base;
        s.kind = RK_NONE;
        base   = '0;
        if (a[1:0] == 2'b00) begin
            if      (in_win(a, OFS_STATUS, banks)) begin s.kind = RK_STATUS; base = OFS_STATUS; end
            else if (in_win(a, OFS_RISE,   banks)) begin s.kind = RK_RISE;   base = OFS_RISE;   end
            else if (in_win(a, OFS_FALL,   banks)) begin s.kind = RK_FALL;   base = OFS_FALL;   end
            else if (in_win(a, OFS_HIGH,   banks)) begin s.kind = RK_HIGH;   base = OFS_HIGH;   end
            else if (in_win(a, OFS_LOW,    banks)) begin s.kind = RK_LOW;    base = OFS_LOW;    end
            else if (in_win(a, OFS_ARISE,  banks)) begin s.kind = RK_ARISE;  base = OFS_ARISE;  end
            else if (in_win(a, OFS_AFALL,  banks)) begin s.kind = RK_AFALL;  base = OFS_AFALL;  end
        end
        s.bank = 2'((a - base) >> 2);
        return s;
    endfunction

endpackage

// File: rtl/gpev_enables.sv
module gpev_enables
    import gpev_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_t            sel,
    input  logic [WORD_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] en_rise,
    output logic [NUM_PINS-1:0] en_fall,
    output logic [NUM_PINS-1:0] en_high,
    output logic [NUM_PINS-1:0] en_low,
    output logic [NUM_PINS-1:0] en_arise,
    output logic [NUM_PINS-1:0] en_afall
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_rise  <= '0;
            en_fall  <= '0;
            en_high  <= '0;
            en_low   <= '0;
            en_arise <= '0;
            en_afall <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (int'(sel.bank) == p / WORD_W) begin
                    case (sel.kind)
                        RK_RISE:  en_rise[p]  <= wdata[p % WORD_W];
                        RK_FALL:  en_fall[p]  <= wdata[p % WORD_W];
                        RK_HIGH:  en_high[p]  <= wdata[p % WORD_W];
                        RK_LOW:   en_low[p]   <= wdata[p % WORD_W];
                        RK_ARISE: en_arise[p] <= wdata[p % WORD_W];
                        RK_AFALL: en_afall[p] <= wdata[p % WORD_W];
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/gpev_detect.sv
module gpev_detect #(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] en_rise,
    input  logic [NUM_PINS-1:0] en_fall,
    input  logic [NUM_PINS-1:0] en_high,
    input  logic [NUM_PINS-1:0] en_low,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] status,
    output logic [NUM_PINS-1:0] evt
);

    logic [NUM_PINS-1:0] lvl_q;

    // Previous level; loaded during reset too so no false edge follows it.
    always_ff @(posedge clk) lvl_q <= pin_lvl;

    always_comb begin
        evt = (en_rise & pin_lvl & ~lvl_q)
            | (en_fall & ~pin_lvl & lvl_q)
            | (en_high & pin_lvl)
            | (en_low  & ~pin_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_mask) | evt;
    end

    // R7 R9
    status_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~status & ~$past(clr_mask)) == '0));

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(evt) & ~status) == '0));

    // R2
    rise_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(en_rise) & $past(pin_lvl) & ~$past(pin_lvl, 2) & ~status) == '0));

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(en_high) & $past(pin_lvl) & ~status) == '0));

endmodule

// File: rtl/gpev_irq_group.sv
module gpev_irq_group #(
    parameter int NUM_PINS = 54,
    parameter int FIRST_B  = 28,
    parameter int FIRST_C  = 46
) (
    input  logic [NUM_PINS-1:0] status,
    output logic [2:0]          irq
);

    for (genvar g = 0; g < 3; g++) begin : g_line
        localparam int LO = (g == 0) ? 0 : (g == 1) ? FIRST_B : FIRST_C;
        localparam int HI = (g == 0) ? FIRST_B - 1 : (g == 1) ? FIRST_C - 1 : NUM_PINS - 1;
        assign irq[g] = |status[HI:LO];
    end

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
    import gpev_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int FIRST_B  = 28,
    parameter int FIRST_C  = 46
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_lvl,
    output logic [2:0]          irq
);

    localparam int BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

    reg_sel_t            sel;
    logic [NUM_PINS-1:0] en_rise, en_fall, en_high, en_low, en_arise, en_afall;
    logic [NUM_PINS-1:0] clr_mask, status, evt;

    assign sel = decode_addr(bus_addr, BANKS);

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            clr_mask[p] = bus_wr && (sel.kind == RK_STATUS)
                       && (int'(sel.bank) == p / WORD_W) && bus_wdata[p % WORD_W];
        end
    end

    gpev_enables #(.NUM_PINS(NUM_PINS)) u_enables (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata),
        .en_rise(en_rise), .en_fall(en_fall), .en_high(en_high), .en_low(en_low),
        .en_arise(en_arise), .en_afall(en_afall)
    );

    gpev_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl),
        .en_rise(en_rise), .en_fall(en_fall), .en_high(en_high), .en_low(en_low),
        .clr_mask(clr_mask), .status(status), .evt(evt)
    );

    gpev_irq_group #(.NUM_PINS(NUM_PINS), .FIRST_B(FIRST_B), .FIRST_C(FIRST_C)) u_irq (
        .status(status), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(sel.bank) == p / WORD_W) begin
                case (sel.kind)
                    RK_STATUS: bus_rdata[p % WORD_W] = status[p];
                    RK_RISE:   bus_rdata[p % WORD_W] = en_rise[p];
                    RK_FALL:   bus_rdata[p % WORD_W] = en_fall[p];
                    RK_HIGH:   bus_rdata[p % WORD_W] = en_high[p];
                    RK_LOW:    bus_rdata[p % WORD_W] = en_low[p];
                    RK_ARISE:  bus_rdata[p % WORD_W] = en_arise[p];
                    RK_AFALL:  bus_rdata[p % WORD_W] = en_afall[p];
                    default: ;
                endcase
            end
        end
    end

    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (|$past(evt)) |-> (irq != 3'b000));

endmodule

// File: tb/gpio_evt_unit_bench.sv
module gpio_evt_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [53:0] pins = '0;
    logic [2:0]  irq;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
        logic [7:0]  addr;
    } item_t;

    item_t q[$];

    always #4 clk = ~clk;

    gpio_evt_unit u_gpio_evt_unit (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lvl(pins), .irq(irq)
    );

    // Monitor: compare queued expectations a little after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_irq ? {29'b0, irq} : bus_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pins[idx] = v;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        q.push_back('{1'b0, e, tag, a});
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        @(negedge clk);
        q.push_back('{1'b1, {29'b0, e}, tag, 8'h00});
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_rd(8'h4C, 32'h0, "R1 rise arm after reset");
        chk_rd(8'h40, 32'h0, "R1 status0 after reset");
        chk_rd(8'h44, 32'h0, "R1 status1 after reset");
        chk_irq(3'b000, "R1 irq after reset");

        // R12 bank 1 width and unmapped offset
        wr(8'h50, 32'hFFFF_FFFF);
        chk_rd(8'h50, 32'h003F_FFFF, "R12 bank1 upper bits read zero");
        wr(8'h50, 32'h0);
        chk_rd(8'h30, 32'h0, "R12 unmapped offset");

        // R2 rising edge, unarmed pin 5 ignored
        wr(8'h4C, 32'h8);
        set_pin(3, 1'b1);
        set_pin(5, 1'b1);
        chk_rd(8'h40, 32'h8, "R2 rise recorded only on armed pin");
        chk_irq(3'b001, "R2 irq line0");

        // R7 write-1-to-clear
        wr(8'h40, 32'h0);
        chk_rd(8'h40, 32'h8, "R7 write zero keeps bit");
        wr(8'h40, 32'h10);
        chk_rd(8'h40, 32'h8, "R7 other bit written keeps bit");
        wr(8'h40, 32'h8);
        chk_rd(8'h40, 32'h0, "R7 write one clears");

        // R3 falling edge
        wr(8'h58, 32'h20);
        set_pin(5, 1'b0);
        chk_rd(8'h40, 32'h20, "R3 fall recorded");
        wr(8'h40, 32'h20);
        chk_rd(8'h40, 32'h0, "R3 cleared");

        // R4 both edges, pin 34 = bank1 bit2
        wr(8'h50, 32'h4);
        wr(8'h5C, 32'h4);
        set_pin(34, 1'b1);
        chk_rd(8'h44, 32'h4, "R4 rise side");
        chk_irq(3'b010, "R4 irq line1");
        wr(8'h44, 32'h4);
        set_pin(34, 1'b0);
        chk_rd(8'h44, 32'h4, "R4 fall side");
        wr(8'h44, 32'h4);
        chk_rd(8'h44, 32'h0, "R4 cleared");

        // R10 group boundaries
        wr(8'h4C, (32'h1 << 27) | (32'h1 << 28));
        wr(8'h50, (32'h1 << 13) | (32'h1 << 14));
        set_pin(27, 1'b1);
        chk_irq(3'b001, "R10 pin27 on line0");
        wr(8'h40, 32'h1 << 27);
        set_pin(28, 1'b1);
        chk_irq(3'b010, "R10 pin28 on line1");
        chk_rd(8'h40, 32'h1000_0000, "R10 pin28 bank0 bit28");
        wr(8'h40, 32'h1 << 28);
        set_pin(45, 1'b1);
        chk_irq(3'b010, "R10 pin45 on line1");
        chk_rd(8'h44, 32'h0000_2000, "R10 pin45 bank1 bit13");
        wr(8'h44, 32'h1 << 13);
        set_pin(46, 1'b1);
        chk_irq(3'b100, "R10 pin46 on line2");
        chk_rd(8'h44, 32'h0000_4000, "R10 pin46 bank1 bit14");
        wr(8'h44, 32'h1 << 14);
        chk_irq(3'b000, "R10 all lines low");

        // R5 high level, R8 event beats clear, R9 pending after disarm
        wr(8'h64, 32'h400);
        set_pin(10, 1'b1);
        chk_rd(8'h40, 32'h400, "R5 high level recorded");
        wr(8'h40, 32'h400);
        chk_rd(8'h40, 32'h400, "R8 level event beats clear");
        wr(8'h64, 32'h0);
        chk_rd(8'h40, 32'h400, "R9 level pending after disarm");
        wr(8'h40, 32'h400);
        chk_rd(8'h40, 32'h0, "R5 stays clear once disarmed");

        // R6 low level on pin 52 = bank1 bit20
        wr(8'h74, 32'h1 << 20);
        chk_rd(8'h44, 32'h0010_0000, "R6 low level recorded");
        chk_irq(3'b100, "R6 irq line2");
        set_pin(52, 1'b1);
        wr(8'h44, 32'h1 << 20);
        chk_rd(8'h44, 32'h0, "R6 stops once pin high");
        wr(8'h74, 32'h0);

        // R9 edge pending after disarm
        set_pin(27, 1'b0);
        set_pin(27, 1'b1);
        wr(8'h4C, 32'h0);
        chk_rd(8'h40, 32'h0800_0000, "R9 edge pending after disarm");
        wr(8'h40, 32'h1 << 27);
        chk_rd(8'h40, 32'h0, "R9 cleared by software");

        // R11 storage-only words
        wr(8'h7C, 32'hDEAD_BEEF);
        chk_rd(8'h7C, 32'hDEAD_BEEF, "R11 async rise word readback");
        wr(8'h8C, 32'h1234_5678);
        chk_rd(8'h8C, 32'h0034_5678, "R11 async fall bank1 readback");
        set_pin(0, 1'b1);
        chk_rd(8'h40, 32'h0, "R11 no status from storage word");
        chk_irq(3'b000, "R11 irq stays low");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule